// File: doc/BRIEF.md
# Paged Management Register Bank

This block is a bank of 16-bit management registers behind a two-wire serial management port: a clock (`mdc`) and a data line that is split into input, output and output-enable. The frame carries a 5-bit register address, so the port can reach only 32 registers at a time. The bank holds four times that many, grouped into four pages of 32. A page-select register appears at the same address on every page. Writing it switches the page that the following frames reach.

Each page holds a small group of per-port event counters, at addresses 16 to 19. The counters are fed by single-cycle event pulses from logic outside this block. A management read of a counter returns its value and then clears it, so software always reads the events since its last read. A shared configuration register holds a bit that keeps the surrounding repeater state machines in reset. The counters keep counting while that bit is set.

The block drives a direction output for an external bidirectional buffer on the data line. It also drives a retimed copy of the management clock so that further devices can be chained.

Top module: `mgmt_page_regbank`

## Requirements
- R1: After reset, page 0 is selected and every register reads 0x0000. The direction output is 0 and the hold output is 0.
- R2: A frame is accepted only after at least 32 consecutive ones on `mdio_in`. The frame then carries the start bits 0 then 1, a 2-bit opcode (10 read, 01 write), a 5-bit device address, a 5-bit register address, two turnaround bits and 16 data bits, all MSB first and sampled on `mdc` rising edges. In a read, the block drives 0 for the second turnaround bit and then the 16 data bits. Each bit is updated just after the `mdc` rising edge on which the previous bit is sampled.
- R3: A write frame stores its data in the addressed register of the current page. Each of the four pages holds its own storage registers (every address other than 0, 1 and 16 to 19).
- R4: Address 1 is the page register on every page. A write to it selects page `data[1:0]`, and a read of it returns the current page number, zero-extended.
- R5: `mdio_oe` is 1 from the second turnaround bit through the last data bit of a read addressed to this device, and 0 at every other time, including during writes and idle.
- R6: On page p, address 16+k reads event counter 4p+k. Each cycle with `evt[4p+k]` high adds one, and the counter saturates at 0xFFFF.
- R7: Reading a counter returns its value and clears it. An event in the clearing cycle leaves the counter at 1.
- R8: Writes to counter addresses do not change the counters.
- R9: A frame whose device address differs from `PHY_ADDR` writes nothing, does not drive the data line and clears no counter.
- R10: A frame preceded by fewer than 32 ones is ignored.
- R11: Address 0 is one configuration register shared by all pages. Its bit 0 drives `core_hold`, and the counters keep counting while `core_hold` is 1.
- R12: `mdc_buf` equals `mdc` delayed by one `clk` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; `mdc` is oversampled in this domain |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock, slower than `clk` |
| mdio_in | input | 1 | Management data line as received |
| mdio_out | output | 1 | Data driven during read turnaround and data bits |
| mdio_oe | output | 1 | Direction: 1 while this block drives the data line |
| mdc_buf | output | 1 | Retimed copy of `mdc` for chaining |
| evt | input | 16 | One pulse per event for each port counter |
| core_hold | output | 1 | Configuration bit 0: hold repeater state machines in reset |

## Verification
The assertions assume three things about the inputs. `mdc` is already synchronous to `clk`. Each `mdc` level lasts several `clk` cycles, so a rising edge is seen once and the request pulses it launches finish before the next edge. `evt` changes only between clock edges.

The bench drives `mdc` with a period of eight `clk` cycles and changes data only while `mdc` is low. It raises events only outside frames, except for one pulse placed on purpose in the cycle that clears a counter. On that footing the checks can be exact to the cycle: direction changes only on `mdc` edges, page and configuration change only when a write lands, a counter never drops except when cleared, and it is at most 1 right after a clear.

// File: rtl/mpr_pkg.sv
`timescale 1ns/1ps
package mpr_pkg;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;

    typedef enum logic [2:0] {
        FS_PRE,
        FS_START,
        FS_OP,
        FS_PHY,
        FS_REG,
        FS_TA,
        FS_DATA
    } frm_state_e;

endpackage

// File: rtl/mpr_mdio_frame.sv
`timescale 1ns/1ps
module mpr_mdio_frame #(
    parameter int REG_W    = 16,
    parameter int ADDR_W   = 5,
    parameter int PHY_W    = 5,
    parameter int PRE_LEN  = 32,
    parameter int PHY_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdc,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              mdc_buf,
    output logic              rd_req,
    output logic              wr_req,
    output logic [ADDR_W-1:0] req_addr,
    output logic [REG_W-1:0]  wr_data,
    input  logic [REG_W-1:0]  rd_data
);
    import mpr_pkg::*;

    localparam int PCW = $clog2(PRE_LEN + 1);
    localparam int CW  = $clog2(REG_W);

    typedef struct packed {
        frm_state_e        state;
        logic [PCW-1:0]    pre_cnt;
        logic [CW-1:0]     bit_cnt;
        logic [1:0]        op;
        logic [PHY_W-1:0]  phy;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  shreg;
        logic              is_rd;
        logic              hit;
        logic              oe;
        logic              dout;
        logic              rd_req;
        logic              wr_req;
    } frm_t;

    frm_t q, d;
    logic mdc_q;
    logic rise;

    // retimed management clock, doubles as edge-detect history
    always_ff @(posedge clk) mdc_q <= mdc;
    assign rise    = mdc & ~mdc_q;
    assign mdc_buf = mdc_q;

    always_comb begin
        d        = q;
        d.rd_req = 1'b0;
        d.wr_req = 1'b0;
        if (rise) begin
            unique case (q.state)
                FS_PRE: begin
                    if (mdio_in) begin
                        if (q.pre_cnt != PCW'(PRE_LEN)) d.pre_cnt = q.pre_cnt + 1'b1;
                    end else begin
                        if (q.pre_cnt == PCW'(PRE_LEN)) d.state = FS_START;
                        d.pre_cnt = '0;
                    end
                end
                FS_START: begin
                    d.state   = mdio_in ? FS_OP : FS_PRE;
                    d.bit_cnt = '0;
                end
                FS_OP: begin
                    d.op = {q.op[0], mdio_in};
                    if (q.bit_cnt == CW'(1)) begin
                        d.state   = FS_PHY;
                        d.bit_cnt = '0;
                    end else begin
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end
                end
                FS_PHY: begin
                    d.phy = {q.phy[PHY_W-2:0], mdio_in};
                    if (q.bit_cnt == CW'(PHY_W - 1)) begin
                        d.state   = FS_REG;
                        d.bit_cnt = '0;
                    end else begin
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end
                end
                FS_REG: begin
                    d.addr = {q.addr[ADDR_W-2:0], mdio_in};
                    if (q.bit_cnt == CW'(ADDR_W - 1)) begin
                        d.bit_cnt = '0;
                        d.hit     = (q.phy == PHY_W'(PHY_ADDR));
                        if (q.op == OP_READ) begin
                            d.state  = FS_TA;
                            d.is_rd  = 1'b1;
                            d.rd_req = d.hit;
                        end else if (q.op == OP_WRITE) begin
                            d.state = FS_TA;
                            d.is_rd = 1'b0;
                        end else begin
                            d.state = FS_PRE;
                        end
                    end else begin
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end
                end
                FS_TA: begin
                    if (q.bit_cnt == '0) begin
                        d.bit_cnt = CW'(1);
                        if (q.is_rd && q.hit) begin
                            d.oe    = 1'b1;
                            d.dout  = 1'b0;
                            d.shreg = rd_data;
                        end
                    end else begin
                        d.state   = FS_DATA;
                        d.bit_cnt = '0;
                        if (q.is_rd) begin
                            d.dout  = q.shreg[REG_W-1];
                            d.shreg = {q.shreg[REG_W-2:0], 1'b0};
                        end
                    end
                end
                FS_DATA: begin
                    if (q.is_rd) begin
                        d.dout  = q.shreg[REG_W-1];
                        d.shreg = {q.shreg[REG_W-2:0], 1'b0};
                    end else begin
                        d.shreg = {q.shreg[REG_W-2:0], mdio_in};
                    end
                    if (q.bit_cnt == CW'(REG_W - 1)) begin
                        d.state   = FS_PRE;
                        d.pre_cnt = '0;
                        d.oe      = 1'b0;
                        d.dout    = 1'b0;
                        d.wr_req  = ~q.is_rd & q.hit;
                    end else begin
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end
                end
                default: d.state = FS_PRE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.state <= FS_PRE;
        end else begin
            q <= d;
        end
    end

    assign mdio_out = q.dout;
    assign mdio_oe  = q.oe;
    assign rd_req   = q.rd_req;
    assign wr_req   = q.wr_req;
    assign req_addr = q.addr;
    assign wr_data  = q.shreg;

    // R5: the direction line only moves right after an mdc rising edge
    p_dir_on_edge_r5: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe != $past(mdio_oe)) |-> $past(rise))
        else $error("direction changed away from an mdc edge");

    // R5: never driving while a write frame clocks its data in
    p_no_dir_on_write_r5: assert property (@(posedge clk) disable iff (rst)
        (q.state == FS_DATA && !q.is_rd) |-> !mdio_oe)
        else $error("direction asserted during write data");

    // R2: read and write requests never launch together
    p_single_req_r2: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (!wr_req && $past(rise)))
        else $error("read request not aligned to an mdc edge");

endmodule

// File: rtl/mpr_evt_counters.sv
`timescale 1ns/1ps
module mpr_evt_counters #(
    parameter int CNT_N = 16,
    parameter int REG_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CNT_N-1:0]         evt,
    input  logic                     clr,
    input  logic [$clog2(CNT_N)-1:0] idx,
    output logic [REG_W-1:0]         rd_val
);
    localparam int IDX_W = $clog2(CNT_N);
    localparam logic [REG_W-1:0] SAT = '1;

    typedef struct packed {
        logic [CNT_N-1:0][REG_W-1:0] cnt;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d = q;
        for (int i = 0; i < CNT_N; i++) begin
            if (clr && idx == IDX_W'(i)) begin
                d.cnt[i] = REG_W'(evt[i]);
            end else if (evt[i] && q.cnt[i] != SAT) begin
                d.cnt[i] = q.cnt[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign rd_val = q.cnt[idx];

    // R7: a cleared counter restarts at 0, or 1 if an event coincided
    p_clear_low_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q.cnt[$past(idx)] <= REG_W'(1)))
        else $error("counter not cleared after read");

    for (genvar g = 0; g < CNT_N; g++) begin : g_mono
        // R6: without a clear a counter never decreases (no wrap)
        p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
            !(clr && idx == IDX_W'(g)) |=> (q.cnt[g] >= $past(q.cnt[g])))
            else $error("counter decreased without clear");
    end

endmodule

// File: rtl/mpr_reg_bank.sv
`timescale 1ns/1ps
module mpr_reg_bank #(
    parameter int REG_W        = 16,
    parameter int ADDR_W       = 5,
    parameter int PAGE_CNT     = 4,
    parameter int CNT_BASE     = 16,
    parameter int CNT_PER_PAGE = 4
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     rd_req,
    input  logic                                     wr_req,
    input  logic [ADDR_W-1:0]                        addr,
    input  logic [REG_W-1:0]                         wr_data,
    output logic [REG_W-1:0]                         rd_data,
    input  logic [REG_W-1:0]                         cnt_val,
    output logic                                     cnt_clr,
    output logic [$clog2(PAGE_CNT*CNT_PER_PAGE)-1:0] cnt_idx,
    output logic                                     core_hold
);
    // CNT_PER_PAGE and PAGE_CNT are powers of two
    localparam int PAGE_W = $clog2(PAGE_CNT);
    localparam int OFS_W  = $clog2(CNT_PER_PAGE);
    localparam int NWORD  = PAGE_CNT << ADDR_W;
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_PAGE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(CNT_BASE);
    localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(CNT_BASE + CNT_PER_PAGE);

    typedef struct packed {
        logic [PAGE_W-1:0]           page;
        logic [REG_W-1:0]            cfg;
        logic [REG_W-1:0]            rdata;
        logic [NWORD-1:0][REG_W-1:0] mem;
    } bank_t;

    bank_t q, d;
    logic  in_cnt;
    logic [ADDR_W-1:0] ofs_full;

    assign in_cnt   = (addr >= A_CLO) && (addr < A_CHI);
    assign ofs_full = addr - A_CLO;
    assign cnt_idx  = {q.page, ofs_full[OFS_W-1:0]};
    assign cnt_clr  = rd_req & in_cnt;

    always_comb begin
        d = q;
        if (rd_req) begin
            if (addr == A_CFG)       d.rdata = q.cfg;
            else if (addr == A_PAGE) d.rdata = REG_W'(q.page);
            else if (in_cnt)         d.rdata = cnt_val;
            else                     d.rdata = q.mem[{q.page, addr}];
        end
        if (wr_req) begin
            if (addr == A_CFG)       d.cfg  = wr_data;
            else if (addr == A_PAGE) d.page = wr_data[PAGE_W-1:0];
            else if (!in_cnt)        d.mem[{q.page, addr}] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign rd_data   = q.rdata;
    assign core_hold = q.cfg[0];

    // R4: page selection moves only when a write lands
    p_page_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_req) |-> $stable(q.page))
        else $error("page changed without a write");

    // R11: the hold bit moves only when a write lands
    p_hold_stable_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_req) |-> $stable(core_hold))
        else $error("hold changed without a write");

endmodule

// File: rtl/mgmt_page_regbank.sv
`timescale 1ns/1ps
module mgmt_page_regbank #(
    parameter int REG_W        = 16,
    parameter int ADDR_W       = 5,
    parameter int PAGE_CNT     = 4,
    parameter int CNT_BASE     = 16,
    parameter int CNT_PER_PAGE = 4,
    parameter int PHY_ADDR     = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             mdc,
    input  logic                             mdio_in,
    output logic                             mdio_out,
    output logic                             mdio_oe,
    output logic                             mdc_buf,
    input  logic [PAGE_CNT*CNT_PER_PAGE-1:0] evt,
    output logic                             core_hold
);
    localparam int CNT_N = PAGE_CNT * CNT_PER_PAGE;
    localparam int IDX_W = $clog2(CNT_N);

    logic              rd_req;
    logic              wr_req;
    logic [ADDR_W-1:0] req_addr;
    logic [REG_W-1:0]  wr_data;
    logic [REG_W-1:0]  rd_data;
    logic [REG_W-1:0]  cnt_val;
    logic              cnt_clr;
    logic [IDX_W-1:0]  cnt_idx;

    mpr_mdio_frame #(
        .REG_W(REG_W), .ADDR_W(ADDR_W), .PHY_W(5), .PRE_LEN(32), .PHY_ADDR(PHY_ADDR)
    ) u_frame (
        .clk(clk), .rst(rst), .mdc(mdc), .mdio_in(mdio_in),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdc_buf(mdc_buf),
        .rd_req(rd_req), .wr_req(wr_req), .req_addr(req_addr),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    mpr_reg_bank #(
        .REG_W(REG_W), .ADDR_W(ADDR_W), .PAGE_CNT(PAGE_CNT),
        .CNT_BASE(CNT_BASE), .CNT_PER_PAGE(CNT_PER_PAGE)
    ) u_bank (
        .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
        .addr(req_addr), .wr_data(wr_data), .rd_data(rd_data),
        .cnt_val(cnt_val), .cnt_clr(cnt_clr), .cnt_idx(cnt_idx),
        .core_hold(core_hold)
    );

    mpr_evt_counters #(
        .CNT_N(CNT_N), .REG_W(REG_W)
    ) u_cnt (
        .clk(clk), .rst(rst), .evt(evt), .clr(cnt_clr),
        .idx(cnt_idx), .rd_val(cnt_val)
    );

    // R12: the chained clock is mdc one cycle later
    p_mdc_copy_r12: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (mdc_buf == $past(mdc)))
        else $error("buffered mdc mismatch");

endmodule

// File: tb/mgmt_page_regbank_bench.sv
`timescale 1ns/1ps
module mgmt_page_regbank_bench;

    localparam int MY_PHY = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mdc = 1'b0;
    logic        mdio_in = 1'b1;
    logic        mdio_out, mdio_oe, mdc_buf, core_hold;
    logic [15:0] evt = '0;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;
    string tag   = "R1";
    logic  exp_oe  = 1'b0;
    logic  exp_out = 1'b0;

    // behavioural model state
    int mstore [4][32];
    int mpage = 0;
    int mcfg  = 0;
    int mcnt  [16];

    always #10 clk = ~clk;

    mgmt_page_regbank #(.PHY_ADDR(MY_PHY)) u_mgmt_page_regbank (
        .clk(clk), .rst(rst), .mdc(mdc), .mdio_in(mdio_in),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdc_buf(mdc_buf),
        .evt(evt), .core_hold(core_hold)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    task automatic cmp();
        chk("R12", int'(mdc_buf), int'(mdc));
        chk({tag, "/R5"}, int'(mdio_oe), int'(exp_oe));
        if (exp_oe) chk({tag, "/R2"}, int'(mdio_out), int'(exp_out));
    endtask

    task automatic bit_cycle(input logic b, input logic noe, input logic nout,
                             input int pidx, output logic samp);
        mdio_in = b;
        mdc     = 1'b0;
        repeat (4) begin @(negedge clk); cmp(); end
        mdc = 1'b1;
        @(negedge clk);
        exp_oe  = noe;
        exp_out = nout;
        samp    = mdio_out;
        cmp();
        if (pidx >= 0) evt[pidx] = 1'b1;
        @(negedge clk);
        evt = '0;
        cmp();
        repeat (2) begin @(negedge clk); cmp(); end
    endtask

    task automatic send_hdr(input logic [1:0] op, input int phy, input int a,
                            input int pre, input int pidx);
        logic s;
        bit_cycle(1'b0, 1'b0, 1'b0, -1, s);
        for (int i = 0; i < pre; i++) bit_cycle(1'b1, 1'b0, 1'b0, -1, s);
        bit_cycle(1'b0, 1'b0, 1'b0, -1, s);
        bit_cycle(1'b1, 1'b0, 1'b0, -1, s);
        for (int i = 1; i >= 0; i--) bit_cycle(op[i], 1'b0, 1'b0, -1, s);
        for (int i = 4; i >= 0; i--) bit_cycle(phy[i], 1'b0, 1'b0, -1, s);
        for (int i = 4; i >= 0; i--) bit_cycle(a[i], 1'b0, 1'b0, (i == 0) ? pidx : -1, s);
    endtask

    task automatic do_write(input string req, input int a, input int dat,
                            input int phy = MY_PHY, input int pre = 32);
        logic s;
        logic [15:0] w = 16'(dat);
        bit hit = (phy == MY_PHY) && (pre >= 32);
        tag = req;
        send_hdr(2'b01, phy, a, pre, -1);
        bit_cycle(1'b1, 1'b0, 1'b0, -1, s);
        bit_cycle(1'b0, 1'b0, 1'b0, -1, s);
        for (int i = 15; i >= 0; i--) bit_cycle(w[i], 1'b0, 1'b0, -1, s);
        if (hit) begin
            if (a == 0)                  mcfg = dat & 16'hffff;
            else if (a == 1)             mpage = dat & 3;
            else if (a < 16 || a >= 20)  mstore[mpage][a] = dat & 16'hffff;
        end
        chk({req, "/R11"}, int'(core_hold), mcfg & 1);
    endtask

    task automatic do_read(input string req, input int a, input int phy = MY_PHY,
                           input int pre = 32, input int pidx = -1);
        logic s;
        logic [15:0] e = '0;
        logic [15:0] got = '0;
        bit hit = (phy == MY_PHY) && (pre >= 32);
        tag = req;
        if (hit) begin
            if (a == 0)                 e = 16'(mcfg);
            else if (a == 1)            e = 16'(mpage);
            else if (a >= 16 && a < 20) e = 16'(mcnt[mpage*4 + a - 16]);
            else                        e = 16'(mstore[mpage][a]);
        end
        send_hdr(2'b10, phy, a, pre, pidx);
        if (hit && a >= 16 && a < 20) mcnt[mpage*4 + a - 16] = (pidx >= 0) ? 1 : 0;
        bit_cycle(1'b1, hit, 1'b0, -1, s);
        bit_cycle(1'b1, hit, hit ? e[15] : 1'b0, -1, s);
        got[15] = s;
        for (int k = 0; k < 15; k++) begin
            bit_cycle(1'b1, hit, hit ? e[14-k] : 1'b0, -1, s);
            got[14-k] = s;
        end
        bit_cycle(1'b1, 1'b0, 1'b0, -1, s);
        if (hit) chk(req, int'(got), int'(e));
    endtask

    task automatic pulse(input int idx, input int n);
        @(negedge clk);
        evt[idx] = 1'b1;
        repeat (n) begin @(negedge clk); cmp(); end
        evt = '0;
        mcnt[idx] = (mcnt[idx] + n > 65535) ? 65535 : mcnt[idx] + n;
    endtask

    initial begin
        foreach (mstore[p, a]) mstore[p][a] = 0;
        foreach (mcnt[i]) mcnt[i] = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", int'(mdio_oe), 0);
        chk("R1", int'(core_hold), 0);
        do_read("R1", 1);
        do_read("R1", 5);
        do_read("R1", 17);

        do_write("R3", 5, 16'hA5A5);
        do_read("R3", 5);
        do_read("R2", 5);

        do_write("R4", 1, 2);
        do_read("R4", 1);
        do_read("R3", 5);
        do_write("R3", 5, 16'h1234);
        do_read("R3", 5);
        do_write("R4", 1, 16'hFFF0);
        do_read("R4", 5);

        do_write("R9", 5, 16'hFFFF, 7);
        do_read("R9", 5, 9);
        do_read("R9", 5);

        do_write("R10", 5, 16'h0F0F, MY_PHY, 31);
        do_read("R10", 5, MY_PHY, 31);
        do_read("R10", 5);

        pulse(1, 5);
        pulse(9, 3);
        pulse(8, 2);
        do_read("R6", 17);
        do_read("R7", 17);
        do_write("R4", 1, 2);
        do_read("R6", 17);
        do_write("R8", 16, 16'h7777);
        do_read("R8", 16);

        do_write("R4", 1, 0);
        pulse(1, 4);
        do_read("R7", 17, MY_PHY, 32, 1);
        do_read("R7", 17);

        do_write("R11", 0, 1);
        pulse(2, 3);
        do_write("R11", 1, 3);
        do_read("R11", 0);
        do_write("R11", 1, 0);
        do_read("R11", 18);
        do_write("R11", 0, 0);

        pulse(15, 65540);
        do_write("R6", 1, 3);
        do_read("R6", 19);
        do_read("R6", 19);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        done = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule